// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between the clock synthesis logic and the clock output pins. It receives two running internal clocks, a CPU-rate clock and a PCI-rate clock. It drives four gated CPU outputs, seven gated PCI outputs and one free-running PCI output. Three asynchronous, active-low pins control the gating: a CPU stop pin, a PCI stop pin and a power-down pin. Each stop request is brought into the domain of the clock it gates. A gate opens or closes only while its source clock is low, so every pulse that reaches an output has its full high width.

Power-down is handled in the reference-clock domain by a small sequencer. When power-down is requested, the sequencer closes every gate, including the free-running one. It then keeps the oscillator and PLL enable high for a fixed number of reference cycles, so that the gates can close on live clocks, and only then drops the enable. When power-down is released, the sequencer raises the enable at once. It keeps all outputs low until the lock indication has been seen high on a programmable number of consecutive reference cycles.

The lock indication must be synchronous to the reference clock. Reset is asynchronous and active low, and its release must be synchronous to the reference clock.

Top module: `clkstop_ctrl`

## Requirements
- R1: While rst_n is low, every clock output and osc_pll_en are low.
- R2: When cpu_stop_n (active low) is sampled low on two successive falling edges of cpu_clk_in, all CPU outputs stay low from the next cpu_clk_in rising edge on. The PCI outputs and the free-running output are unaffected.
- R3: When pci_stop_n (active low) is sampled low on two successive falling edges of pci_clk_in, all seven gated PCI outputs stay low. pci_free_out and the CPU outputs keep toggling.
- R4: While power-down is in effect (pwrdn_n active low), every output is low whatever the stop pins do, and toggling the stop pins has no effect at the outputs.
- R5: From the running state, osc_pll_en stays high after pwrdn_n falls and goes low on the (3 + DRAIN_CYCLES)-th rising edge of ref_clk after the fall.
- R6: After pwrdn_n returns high, osc_pll_en rises on the third rising edge of ref_clk. The outputs resume only after lock_done has been sampled high on LOCK_CYCLES consecutive ref_clk rising edges; a low sample restarts the count.
- R7: Every high pulse on a gated output is exactly as wide as the high phase of its source clock; no runt pulse ever appears.
- R8: When a stop pin is released, the affected outputs resume after two falling edges of their source clock that sample the pin high, starting with a full high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the power sequencer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to ref_clk |
| cpu_clk_in | input | 1 | Running CPU-rate clock to be gated |
| pci_clk_in | input | 1 | Running PCI-rate clock to be gated |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU clock stop |
| pci_stop_n | input | 1 | Asynchronous active-low PCI clock stop |
| pwrdn_n | input | 1 | Asynchronous active-low power-down |
| lock_done | input | 1 | PLL lock indication, synchronous to ref_clk |
| cpu_clk_out | output | N_CPU (4) | Gated CPU clock outputs |
| pci_clk_out | output | N_PCI (7) | Gated PCI clock outputs |
| pci_free_out | output | 1 | PCI output that ignores the PCI stop pin |
| osc_pll_en | output | 1 | Enable for the oscillator and PLLs |

## Verification
A wrong synchronizer stage or gate register shows up at the outputs as a clock that stops or restarts one source period early or late. It can also show up as a pulse cut short. The per-cycle comparison catches the first of these within one CPU period, and the edge-to-edge width monitor catches the second on the pulse where it happens. A fault in the sequencer's counter or state moves the osc_pll_en edge, or the first resumed output pulse, by at least one reference cycle. Both are compared on every reference clock.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Power sequencer states
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,  // oscillator and PLLs disabled
    PS_LOCK  = 2'd1,  // enabled, waiting for stable lock
    PS_RUN   = 2'd2,  // outputs allowed to run
    PS_DRAIN = 2'd3   // gates closing, enable still held
  } pwr_state_e;

endpackage

// File: rtl/clkstop_pwrseq.sv
module clkstop_pwrseq
  import clkstop_pkg::*;
#(
  parameter int LOCK_CYCLES  = 16,
  parameter int DRAIN_CYCLES = 8
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pwrdn_n,
  input  logic lock_done,
  output logic run_ok,
  output logic osc_pll_en
);

  localparam int CNT_MAX = (LOCK_CYCLES > DRAIN_CYCLES) ? LOCK_CYCLES : DRAIN_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOCK_LAST  = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_CYCLES - 1);

  logic             pd_s1_q, pd_s2_q;
  pwr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             osc_q, osc_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_OFF: begin
        if (pd_s2_q) begin
          state_d = PS_LOCK;
          cnt_d   = '0;
        end
      end
      PS_LOCK: begin
        if (!pd_s2_q) begin
          state_d = PS_OFF;
          cnt_d   = '0;
        end else if (!lock_done) begin
          cnt_d = '0;
        end else if (cnt_q == LOCK_LAST) begin
          state_d = PS_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PS_RUN: begin
        if (!pd_s2_q) begin
          state_d = PS_DRAIN;
          cnt_d   = '0;
        end
      end
      PS_DRAIN: begin
        if (cnt_q == DRAIN_LAST) begin
          state_d = PS_OFF;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = PS_OFF;
        cnt_d   = '0;
      end
    endcase
    run_d = (state_d == PS_RUN);
    osc_d = (state_d != PS_OFF);
  end

  // registers
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_s1_q <= 1'b0;
      pd_s2_q <= 1'b0;
      state_q <= PS_OFF;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      osc_q   <= 1'b0;
    end else begin
      pd_s1_q <= pwrdn_n;
      pd_s2_q <= pd_s1_q;
      state_q <= state_d;
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      osc_q   <= osc_d;
    end
  end

  assign run_ok     = run_q;
  assign osc_pll_en = osc_q;

  AST_RUN_AFTER_LOCK: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(run_ok) |-> ($past(lock_done) && $past(lock_done, 2))); // R6
  AST_DRAIN_HOLDS_OSC: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(run_ok) |-> osc_pll_en); // R5
  AST_RUN_NEEDS_PWR: assert property (@(posedge ref_clk) disable iff (!rst_n)
    run_ok |-> $past(pwrdn_n, 3)); // R4

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int WIDTH = 4
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             en_async,
  output logic [WIDTH-1:0] clk_out
);

  logic sync1_q, sync2_q;
  logic sync1_d, sync2_d;

  // next-state: plain two-stage shift of the asynchronous enable
  always_comb begin
    sync1_d = en_async;
    sync2_d = sync1_q;
  end

  // falling-edge registers: the gate only moves while clk_in is low
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= sync1_d;
      sync2_q <= sync2_d;
    end
  end

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_out
    assign clk_out[gi] = clk_in & sync2_q;
  end

  AST_STOP_AFTER_TWO: assert property (@(negedge clk_in) disable iff (!rst_n)
    (!en_async && $past(!en_async)) |=> !sync2_q); // R2
  AST_START_AFTER_TWO: assert property (@(negedge clk_in) disable iff (!rst_n)
    (en_async && $past(en_async)) |=> sync2_q); // R8

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int N_CPU        = 4,
  parameter int N_PCI        = 7,
  parameter int LOCK_CYCLES  = 16,
  parameter int DRAIN_CYCLES = 8
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             cpu_clk_in,
  input  logic             pci_clk_in,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwrdn_n,
  input  logic             lock_done,
  output logic [N_CPU-1:0] cpu_clk_out,
  output logic [N_PCI-1:0] pci_clk_out,
  output logic             pci_free_out,
  output logic             osc_pll_en
);

  logic run_ok;
  logic cpu_en, pci_en;
  logic free_vec;

  clkstop_pwrseq #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .DRAIN_CYCLES(DRAIN_CYCLES)
  ) u_seq (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .pwrdn_n   (pwrdn_n),
    .lock_done (lock_done),
    .run_ok    (run_ok),
    .osc_pll_en(osc_pll_en)
  );

  // power-down overrides both stop pins
  assign cpu_en = cpu_stop_n & run_ok;
  assign pci_en = pci_stop_n & run_ok;

  clkstop_gate #(.WIDTH(N_CPU)) u_cpu_gate (
    .clk_in  (cpu_clk_in),
    .rst_n   (rst_n),
    .en_async(cpu_en),
    .clk_out (cpu_clk_out)
  );

  clkstop_gate #(.WIDTH(N_PCI)) u_pci_gate (
    .clk_in  (pci_clk_in),
    .rst_n   (rst_n),
    .en_async(pci_en),
    .clk_out (pci_clk_out)
  );

  // free-running output obeys power-down only
  clkstop_gate #(.WIDTH(1)) u_free_gate (
    .clk_in  (pci_clk_in),
    .rst_n   (rst_n),
    .en_async(run_ok),
    .clk_out (free_vec)
  );

  assign pci_free_out = free_vec;

  AST_RESET_QUIET: assert property (@(posedge ref_clk)
    !rst_n |-> (!osc_pll_en && !run_ok)); // R1

endmodule

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;

  localparam int N_CPU = 4;
  localparam int N_PCI = 7;
  localparam int LOCK  = 16;
  localparam int DRAIN = 8;

  logic ref_clk = 1'b0;
  logic rst_n;
  logic cpu_clk = 1'b0;
  logic pci_clk = 1'b0;
  logic pci_ph  = 1'b0;
  logic cpu_stop_n, pci_stop_n, pwrdn_n, lock_done;
  logic [N_CPU-1:0] cpu_out;
  logic [N_PCI-1:0] pci_out;
  logic free_out, osc_en;

  int n_cmp = 0;
  int n_bad = 0;
  logic cmp_en = 1'b0;

  // behavioural reference state
  int m_s1 = 0, m_s2 = 0, m_mode = 0, m_cnt = 0, m_nmode = 0, m_ncnt = 0;
  int m_run = 0, m_osc = 0;
  int mc1 = 0, mc2 = 0, mp1 = 0, mp2 = 0, mf1 = 0, mf2 = 0;

  logic [N_CPU-1:0] obs_cpu;
  logic [N_PCI-1:0] obs_pci;
  logic obs_free;

  clkstop_ctrl #(
    .N_CPU(N_CPU), .N_PCI(N_PCI), .LOCK_CYCLES(LOCK), .DRAIN_CYCLES(DRAIN)
  ) u_clkstop_ctrl (
    .ref_clk(ref_clk), .rst_n(rst_n), .cpu_clk_in(cpu_clk), .pci_clk_in(pci_clk),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
    .lock_done(lock_done), .cpu_clk_out(cpu_out), .pci_clk_out(pci_out),
    .pci_free_out(free_out), .osc_pll_en(osc_en)
  );

  always #2 ref_clk = ~ref_clk;  // 250 MHz

  // reference model and derived source clocks
  always @(posedge ref_clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_mode = 0; m_cnt = 0; m_run = 0; m_osc = 0;
    end else begin
      m_nmode = m_mode; m_ncnt = m_cnt;
      if (m_mode == 0) begin
        if (m_s2 == 1) begin m_nmode = 1; m_ncnt = 0; end
      end else if (m_mode == 1) begin
        if (m_s2 == 0) begin m_nmode = 0; m_ncnt = 0; end
        else if (!lock_done) m_ncnt = 0;
        else if (m_cnt == LOCK - 1) begin m_nmode = 2; m_ncnt = 0; end
        else m_ncnt = m_cnt + 1;
      end else if (m_mode == 2) begin
        if (m_s2 == 0) begin m_nmode = 3; m_ncnt = 0; end
      end else begin
        if (m_cnt == DRAIN - 1) begin m_nmode = 0; m_ncnt = 0; end
        else m_ncnt = m_cnt + 1;
      end
      m_s2 = m_s1; m_s1 = int'(pwrdn_n);
      m_mode = m_nmode; m_cnt = m_ncnt;
      m_run = (m_mode == 2) ? 1 : 0;
      m_osc = (m_mode != 0) ? 1 : 0;
    end
    #1;
    if (!rst_n) begin
      mc1 = 0; mc2 = 0; mp1 = 0; mp2 = 0; mf1 = 0; mf2 = 0;
    end else begin
      if (cpu_clk) begin mc2 = mc1; mc1 = int'(cpu_stop_n) & m_run; end
      if (pci_ph && pci_clk) begin
        mp2 = mp1; mp1 = int'(pci_stop_n) & m_run;
        mf2 = mf1; mf1 = m_run;
      end
    end
    cpu_clk = ~cpu_clk;
    if (pci_ph) pci_clk = ~pci_clk;
    pci_ph = ~pci_ph;
  end

  // per-clock comparison against the model
  always @(negedge ref_clk) begin
    if (cmp_en) begin
      n_cmp++;
      if (int'(osc_en) != m_osc) begin
        n_bad++;
        $display("FAIL R5/R6 osc_pll_en got %0b exp %0d at %0t", osc_en, m_osc, $time);
      end
      for (int i = 0; i < N_CPU; i++) begin
        n_cmp++;
        if (int'(cpu_out[i]) != (int'(cpu_clk) & mc2)) begin
          n_bad++;
          $display("FAIL R2 cpu_out[%0d] got %0b exp %0d at %0t", i, cpu_out[i], int'(cpu_clk) & mc2, $time);
        end
      end
      for (int i = 0; i < N_PCI; i++) begin
        n_cmp++;
        if (int'(pci_out[i]) != (int'(pci_clk) & mp2)) begin
          n_bad++;
          $display("FAIL R3 pci_out[%0d] got %0b exp %0d at %0t", i, pci_out[i], int'(pci_clk) & mp2, $time);
        end
      end
      n_cmp++;
      if (int'(free_out) != (int'(pci_clk) & mf2)) begin
        n_bad++;
        $display("FAIL R3 pci_free_out got %0b exp %0d at %0t", free_out, int'(pci_clk) & mf2, $time);
      end
    end
  end

  // R7 pulse-width monitors
  time tr_c = 0, tr_p = 0, tr_f = 0;
  always @(posedge cpu_out[0]) tr_c = $time;
  always @(posedge pci_out[0]) tr_p = $time;
  always @(posedge free_out)   tr_f = $time;
  always @(negedge cpu_out[0]) if (cmp_en) begin
    n_cmp++;
    if ($time - tr_c != 4) begin n_bad++; $display("FAIL R7 cpu pulse width got %0t exp 4", $time - tr_c); end
  end
  always @(negedge pci_out[0]) if (cmp_en) begin
    n_cmp++;
    if ($time - tr_p != 8) begin n_bad++; $display("FAIL R7 pci pulse width got %0t exp 8", $time - tr_p); end
  end
  always @(negedge free_out) if (cmp_en) begin
    n_cmp++;
    if ($time - tr_f != 8) begin n_bad++; $display("FAIL R7 free pulse width got %0t exp 8", $time - tr_f); end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic observe(input int n);
    obs_cpu = '0; obs_pci = '0; obs_free = 1'b0;
    repeat (n) begin
      @(negedge ref_clk);
      obs_cpu = obs_cpu | cpu_out;
      obs_pci = obs_pci | pci_out;
      obs_free = obs_free | free_out;
    end
  endtask

  task automatic chk(input logic ok, input string tag, input int got, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge ref_clk);
    n_bad++;
    $display("FAIL R1 watchdog got running exp finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; pwrdn_n = 1'b1; cpu_stop_n = 1'b1; pci_stop_n = 1'b1; lock_done = 1'b0;
    wait_cyc(6);
    // R1 reset state
    chk(osc_en == 1'b0, "R1 osc_pll_en in reset", int'(osc_en), 0);
    chk(cpu_out == '0 && pci_out == '0 && free_out == 1'b0, "R1 outputs in reset",
        int'({cpu_out, pci_out, free_out}), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R6 enable up, no lock yet: outputs held low
    wait_cyc(2);
    chk(osc_en == 1'b0, "R6 osc before third edge", int'(osc_en), 0);
    wait_cyc(1);
    chk(osc_en == 1'b1, "R6 osc on third edge", int'(osc_en), 1);
    observe(30);
    chk(obs_cpu == '0 && obs_pci == '0 && !obs_free, "R6 low while unlocked",
        int'({obs_cpu, obs_pci, obs_free}), 0);

    // R6 lock interrupted restarts the count
    lock_done = 1'b1; wait_cyc(10);
    lock_done = 1'b0; wait_cyc(1);
    lock_done = 1'b1;
    observe(15);
    chk(obs_cpu == '0 && !obs_free, "R6 no run before full lock count",
        int'({obs_cpu, obs_free}), 0);
    wait_cyc(10);
    observe(4);
    chk(obs_cpu == '1 && obs_pci == '1 && obs_free, "R6 running after lock",
        int'({obs_cpu, obs_pci, obs_free}), (1 << (N_CPU + N_PCI + 1)) - 1);

    // R2 CPU stop only
    cpu_stop_n = 1'b0; wait_cyc(8);
    observe(4);
    chk(obs_cpu == '0, "R2 cpu stopped", int'(obs_cpu), 0);
    chk(obs_pci == '1 && obs_free, "R2 pci unaffected", int'({obs_pci, obs_free}), 255);
    cpu_stop_n = 1'b1; wait_cyc(8);
    observe(4);
    chk(obs_cpu == '1, "R8 cpu resumed", int'(obs_cpu), 15);

    // R3 PCI stop: free output keeps running
    pci_stop_n = 1'b0; wait_cyc(12);
    observe(4);
    chk(obs_pci == '0, "R3 pci stopped", int'(obs_pci), 0);
    chk(obs_free == 1'b1, "R3 free keeps running", int'(obs_free), 1);
    chk(obs_cpu == '1, "R3 cpu unaffected", int'(obs_cpu), 15);
    pci_stop_n = 1'b1; wait_cyc(12);
    observe(4);
    chk(obs_pci == '1, "R8 pci resumed", int'(obs_pci), 127);

    // R7 rapid stop-pin activity; widths checked by monitors
    for (int i = 0; i < 40; i++) begin
      cpu_stop_n = ((i % 3) != 0);
      pci_stop_n = ((i % 5) < 2);
      wait_cyc(1);
    end
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    wait_cyc(20);

    // R5 drain then enable drop
    pwrdn_n = 1'b0;
    wait_cyc(10);
    chk(osc_en == 1'b1, "R5 osc held during drain", int'(osc_en), 1);
    wait_cyc(1);
    chk(osc_en == 1'b0, "R5 osc dropped after drain", int'(osc_en), 0);

    // R4 stop pins have no effect while powered down
    observe(4);
    chk(obs_cpu == '0 && obs_pci == '0 && !obs_free, "R4 all low in power-down",
        int'({obs_cpu, obs_pci, obs_free}), 0);
    for (int i = 0; i < 12; i++) begin
      cpu_stop_n = i[0];
      pci_stop_n = i[1];
      wait_cyc(1);
    end
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    observe(8);
    chk(obs_cpu == '0 && obs_pci == '0 && !obs_free, "R4 stop pins ignored while down",
        int'({obs_cpu, obs_pci, obs_free}), 0);
    chk(osc_en == 1'b0, "R4 osc stays off", int'(osc_en), 0);

    // R4 power-down with stops asserted, then recover with lock held
    cpu_stop_n = 1'b0;
    pwrdn_n = 1'b1;
    wait_cyc(30);
    observe(4);
    chk(obs_cpu == '0 && obs_pci == '1, "R2 cpu still stopped after recovery",
        int'({obs_cpu, obs_pci}), 127);
    cpu_stop_n = 1'b1;
    wait_cyc(8);
    observe(4);
    chk(obs_cpu == '1 && obs_free, "R8 all running after recovery",
        int'({obs_cpu, obs_free}), 31);

    // power-down straight out of lock wait (R6 abort)
    pwrdn_n = 1'b0; wait_cyc(20);
    pwrdn_n = 1'b1; lock_done = 1'b0; wait_cyc(6);
    pwrdn_n = 1'b0; wait_cyc(6);
    chk(osc_en == 1'b0, "R6 lock wait aborted by power-down", int'(osc_en), 0);
    wait_cyc(10);
    summary();
  end

endmodule